// File: doc/BRIEF.md
# Design Revision Selector and Sampler

This block decides which of up to four stored configuration images (design revisions) the configuration output streams from. A revision number comes either from a two-bit select on external pins or from two internal programmable bits, with a source-select input choosing between them. The choice is not followed continuously. It is captured only when a defined event occurs: power-up, deassertion of the chip enable, a falling output-enable/reset or a rising configuration-request line while the chip is enabled, or a configuration request over the test port.

At the moment of capture, the revision is looked up in a small writable table. Each table entry holds a start block index and a block count, and a block is 2^23 bits. The block registers the revision number together with the first and last bit address of its region. A revision whose table entry has a block count of zero is flagged as invalid, and revision 0 is presented in its place. A test-port configuration request also produces a one-cycle start pulse, and that pulse is issued only after the new selection has been captured.

Top module: `revsel_top`

## Requirements
- R1: After reset, rev_num is 0, start_addr is 0, end_addr is 0, sel_invalid is 0 and cfg_start is 0. The table resets to entry i = {start block i, count 1}.
- R2: When a capture occurs, the candidate revision is int_rev if use_int is 1. If use_int is 0, the candidate is ext_rev, after ext_rev has passed through a two-stage synchroniser.
- R3: A rising edge (0 to 1) on chip_en_n causes a capture. A falling edge on chip_en_n does not.
- R4: A falling edge on oe_rst_n causes a capture only while chip_en_n is low. While chip_en_n is high, the same edge leaves every output unchanged.
- R5: A rising edge on cfg_n causes a capture only while chip_en_n is low. While chip_en_n is high, the same edge leaves every output unchanged.
- R6: When no capture event occurs, the outputs do not change, even if the select inputs, use_int or the table contents change.
- R7: A one-cycle pulse on jtag_cfg causes a capture at the next clock edge. cfg_start is high for exactly one cycle, starting one clock after the captured outputs appear.
- R8: If pwr_up is high, a capture occurs on the first clock edge after reset is released. If pwr_up is low, no capture occurs then.
- R9: For the captured entry {S, C}, start_addr equals S*2^23 and end_addr equals (S+C)*2^23-1.
- R10: If the candidate's entry has a count of 0, sel_invalid is 1, rev_num is 0 and the addresses come from entry 0. Otherwise sel_invalid is 0 and rev_num is the candidate.
- R11: Writing through tbl_wr with tbl_idx, tbl_start and tbl_count replaces that entry. The new contents take effect at the next capture, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up | input | 1 | Power-up indication; requests capture at first clock after reset |
| chip_en_n | input | 1 | Active-low chip enable pin (asynchronous) |
| oe_rst_n | input | 1 | Active-low output-enable/reset pin (asynchronous) |
| cfg_n | input | 1 | Active-low configuration-request pin (asynchronous) |
| ext_rev | input | 2 | External revision select pins (asynchronous) |
| int_rev | input | 2 | Internal programmable revision bits |
| use_int | input | 1 | 1 selects int_rev, 0 selects ext_rev |
| jtag_cfg | input | 1 | Single-cycle configuration request from the test port |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Table entry to write |
| tbl_start | input | 3 | Start block index to write |
| tbl_count | input | 3 | Block count to write |
| rev_num | output | 2 | Captured revision number |
| start_addr | output | 27 | First bit address of captured revision |
| end_addr | output | 27 | Last bit address of captured revision |
| sel_invalid | output | 1 | Selected entry had zero blocks; revision 0 used |
| cfg_start | output | 1 | Configuration-start pulse following a test-port request |

## Verification
The assertions assume that jtag_cfg is a pulse synchronous to clk. They also assume that the table's block start plus count fits in one bit more than the index width, so end_addr never wraps below start_addr. The stimulus holds each pin for several clocks, so the synchroniser and edge registers settle. It also keeps entry 0 at a nonzero count, so the fallback region is always well formed. Table writes and select changes are made well before any capture event, so no capture lands at the same edge as a write.

// File: rtl/revsel_pkg.sv
// Shared types for the revision selector.
// Assumes at most four revisions, addressed by a two-bit number.
package revsel_pkg;
    localparam int REV_W    = 2;
    localparam int NUM_REVS = 1 << REV_W;
    typedef logic [REV_W-1:0] rev_t;
endpackage

// File: rtl/revsel_sync.sv
// Two-stage synchroniser for a multi-bit level that changes slowly.
// Assumes the bits are quasi-static, so skew between them across stages is harmless.
module revsel_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/revsel_edge.sv
// Synchronises a single control pin and flags its edges in the clock domain.
// Assumes the pin holds each level for at least two clocks; RST_VAL is its idle level.
module revsel_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    revsel_sync #(.W(1), .RST_VAL(RST_VAL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (level)
    );

    // Hold the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    // Compare current and previous level.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
    end
endmodule

// File: rtl/revsel_table.sv
// Writable table of {start block, block count}, one entry per revision.
// Has one indexed read port and one fixed read of entry 0 for the fallback path.
// A write becomes visible to reads on the clock after the strobe.
module revsel_table
    import revsel_pkg::*;
#(
    parameter int BLK_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  rev_t             wr_idx,
    input  logic [BLK_W-1:0] wr_start,
    input  logic [CNT_W-1:0] wr_count,
    input  rev_t             rd_idx,
    output logic [BLK_W-1:0] rd_start,
    output logic [CNT_W-1:0] rd_count,
    output logic [BLK_W-1:0] base_start,
    output logic [CNT_W-1:0] base_count
);
    logic [BLK_W-1:0] start_q [NUM_REVS];
    logic [CNT_W-1:0] count_q [NUM_REVS];

    for (genvar i = 0; i < NUM_REVS; i++) begin : g_entry
        // Each entry resets to one block placed at block index i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[i] <= BLK_W'(i);
                count_q[i] <= CNT_W'(1);
            end else if (wr && (wr_idx == rev_t'(i))) begin
                start_q[i] <= wr_start;
                count_q[i] <= wr_count;
            end
        end
    end

    // Read port for the candidate revision and the fixed fallback entry.
    always_comb begin
        rd_start   = start_q[rd_idx];
        rd_count   = count_q[rd_idx];
        base_start = start_q[0];
        base_count = count_q[0];
    end
endmodule

// File: rtl/revsel_trigger.sv
// Merges the capture events into a single sample strobe and issues the
// configuration-start pulse one clock after a test-port capture.
// Assumes jtag_cfg is synchronous to clk.
module revsel_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic ce_level,
    input  logic ce_rise,
    input  logic oe_fall,
    input  logic cf_rise,
    input  logic jtag_cfg,
    output logic sample_en,
    output logic cfg_start
);
    logic first_q;
    logic pend_q;
    logic gated;

    // Flag the first clock after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    // Pins other than chip enable only count while the chip is enabled (level low).
    always_comb begin
        gated     = ~ce_level & (oe_fall | cf_rise);
        sample_en = rst_n & ((first_q & pwr_up) | ce_rise | gated | jtag_cfg);
    end

    // Two-stage pulse: capture first, then the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            cfg_start <= 1'b0;
        end else begin
            pend_q    <= jtag_cfg;
            cfg_start <= pend_q;
        end
    end
endmodule

// File: rtl/revsel_top.sv
// Top of the revision selector. Picks the revision source, looks the candidate up
// in the table, and registers number, address bounds and invalid flag on a capture.
// Assumes asynchronous pins are held steady for several clocks around each edge.
module revsel_top
    import revsel_pkg::*;
#(
    parameter int BLK_W    = 3,
    parameter int CNT_W    = 3,
    parameter int BLK_BITS = 23,
    localparam int SUM_W   = ((BLK_W > CNT_W) ? BLK_W : CNT_W) + 1,
    localparam int ADDR_W  = SUM_W + BLK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              chip_en_n,
    input  logic              oe_rst_n,
    input  logic              cfg_n,
    input  logic [1:0]        ext_rev,
    input  logic [1:0]        int_rev,
    input  logic              use_int,
    input  logic              jtag_cfg,
    input  logic              tbl_wr,
    input  logic [1:0]        tbl_idx,
    input  logic [BLK_W-1:0]  tbl_start,
    input  logic [CNT_W-1:0]  tbl_count,
    output logic [1:0]        rev_num,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    output logic              sel_invalid,
    output logic              cfg_start
);
    rev_t             ext_q;
    logic             ce_level, ce_rise, ce_fall;
    logic             oe_level, oe_rise, oe_fall;
    logic             cf_level, cf_rise, cf_fall;
    logic             sample_en;
    rev_t             cand;
    logic [BLK_W-1:0] rd_start, base_start, eff_start;
    logic [CNT_W-1:0] rd_count, base_count, eff_count;
    logic             eff_inv;
    rev_t             eff_rev;
    logic [ADDR_W-1:0] start_d, end_d;

    revsel_sync #(.W(REV_W), .RST_VAL('0)) u_ext_sync (
        .clk (clk), .rst_n (rst_n), .d (ext_rev), .q (ext_q)
    );

    revsel_edge #(.RST_VAL(1'b1)) u_ce_edge (
        .clk (clk), .rst_n (rst_n), .pin (chip_en_n),
        .level (ce_level), .rise (ce_rise), .fall (ce_fall)
    );

    revsel_edge #(.RST_VAL(1'b1)) u_oe_edge (
        .clk (clk), .rst_n (rst_n), .pin (oe_rst_n),
        .level (oe_level), .rise (oe_rise), .fall (oe_fall)
    );

    revsel_edge #(.RST_VAL(1'b1)) u_cf_edge (
        .clk (clk), .rst_n (rst_n), .pin (cfg_n),
        .level (cf_level), .rise (cf_rise), .fall (cf_fall)
    );

    revsel_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up    (pwr_up),
        .ce_level  (ce_level),
        .ce_rise   (ce_rise),
        .oe_fall   (oe_fall),
        .cf_rise   (cf_rise),
        .jtag_cfg  (jtag_cfg),
        .sample_en (sample_en),
        .cfg_start (cfg_start)
    );

    revsel_table #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (tbl_wr),
        .wr_idx     (tbl_idx),
        .wr_start   (tbl_start),
        .wr_count   (tbl_count),
        .rd_idx     (cand),
        .rd_start   (rd_start),
        .rd_count   (rd_count),
        .base_start (base_start),
        .base_count (base_count)
    );

    // Choose the revision source.
    always_comb begin
        cand = use_int ? int_rev : ext_q;
    end

    // Apply the zero-count fallback and form the bit-address bounds.
    always_comb begin
        eff_inv   = (rd_count == '0);
        eff_rev   = eff_inv ? rev_t'(0) : cand;
        eff_start = eff_inv ? base_start : rd_start;
        eff_count = eff_inv ? base_count : rd_count;
        start_d   = ADDR_W'(eff_start) << BLK_BITS;
        end_d     = ((ADDR_W'(eff_start) + ADDR_W'(eff_count)) << BLK_BITS) - ADDR_W'(1);
    end

    // Capture the mapped selection only on a sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_num     <= '0;
            start_addr  <= '0;
            end_addr    <= '0;
            sel_invalid <= 1'b0;
        end else if (sample_en) begin
            rev_num     <= eff_rev;
            start_addr  <= start_d;
            end_addr    <= end_d;
            sel_invalid <= eff_inv;
        end
    end
endmodule

// File: rtl/revsel_chk.sv
// Property checker for revsel_top, attached by bind.
module revsel_chk #(
    parameter int ADDR_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic [1:0]        rev_num,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] end_addr,
    input logic              sel_invalid,
    input logic              cfg_start
);
    // Outputs move only on the clock after a sample strobe.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_en) |-> ($stable(rev_num) && $stable(start_addr)
                               && $stable(end_addr) && $stable(sel_invalid)));

    // An invalid selection always presents revision 0.
    assert_fallback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_invalid |-> (rev_num == 2'd0));

    // The start pulse follows a capture by two clocks.
    assert_cfg_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_start) |-> $past(sample_en, 2));

    // The start pulse lasts one cycle.
    assert_cfg_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start);

    // A valid region never ends before it starts.
    assert_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_invalid |-> (end_addr >= start_addr));
endmodule

bind revsel_top revsel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .rev_num     (rev_num),
    .start_addr  (start_addr),
    .end_addr    (end_addr),
    .sel_invalid (sel_invalid),
    .cfg_start   (cfg_start)
);

// File: tb/revsel_top_bench.sv
module revsel_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up = 1'b0;
    logic chip_en_n = 1'b1, oe_rst_n = 1'b1, cfg_n = 1'b1;
    logic [1:0] ext_rev = 2'd0, int_rev = 2'd0;
    logic use_int = 1'b0, jtag_cfg = 1'b0;
    logic tbl_wr = 1'b0;
    logic [1:0] tbl_idx = 2'd0;
    logic [2:0] tbl_start = 3'd0, tbl_count = 3'd0;
    logic [1:0] rev_num;
    logic [AW-1:0] start_addr, end_addr;
    logic sel_invalid, cfg_start;

    int checks = 0;
    int fails = 0;
    int m_start [4];
    int m_count [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    revsel_top u_revsel_top (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .chip_en_n(chip_en_n),
        .oe_rst_n(oe_rst_n), .cfg_n(cfg_n), .ext_rev(ext_rev), .int_rev(int_rev),
        .use_int(use_int), .jtag_cfg(jtag_cfg), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
        .tbl_start(tbl_start), .tbl_count(tbl_count), .rev_num(rev_num),
        .start_addr(start_addr), .end_addr(end_addr), .sel_invalid(sel_invalid),
        .cfg_start(cfg_start)
    );

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_start[i] = i; m_count[i] = 1; end
    endtask

    task automatic do_reset(input logic pu);
        rst_n = 1'b0; pwr_up = pu;
        chip_en_n = 1'b1; oe_rst_n = 1'b1; cfg_n = 1'b1;
        wait_n(4);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic chk_raw(input string tag, input int er, input int es,
                           input longint ee, input bit ei);
        checks++;
        if (rev_num !== er[1:0] || start_addr !== AW'(es) || end_addr !== AW'(ee)
            || sel_invalid !== ei) begin
            fails++;
            $display("FAIL %s: got rev=%0d start=%h end=%h inv=%0d exp rev=%0d start=%h end=%h inv=%0d",
                     tag, rev_num, start_addr, end_addr, sel_invalid,
                     er, AW'(es), AW'(ee), ei);
        end
    endtask

    // Expected outputs after capturing revision r, from the model table.
    task automatic chk_rev(input string tag, input int r);
        int e; bit inv; longint s; longint en;
        inv = (m_count[r] == 0);
        e = inv ? 0 : r;
        s = longint'(m_start[e]) << 23;
        en = ((longint'(m_start[e]) + longint'(m_count[e])) << 23) - 1;
        chk_raw(tag, e, int'(s), en, inv);
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic wr_entry(input int i, input int s, input int c);
        tbl_wr = 1'b1; tbl_idx = i[1:0]; tbl_start = s[2:0]; tbl_count = c[2:0];
        wait_n(1);
        tbl_wr = 1'b0;
        m_start[i] = s; m_count[i] = c;
        wait_n(2);
    endtask

    task automatic set_sel(input bit src, input int r);
        use_int = src;
        if (src) begin int_rev = r[1:0]; ext_rev = 2'(3 - r); end
        else     begin ext_rev = r[1:0]; int_rev = 2'(3 - r); end
        wait_n(4);
    endtask

    // Event kinds: 0 chip enable rise, 1 oe fall, 2 cfg rise, 3 test-port request.
    task automatic fire(input int kind);
        case (kind)
            0: begin chip_en_n = 1'b0; wait_n(4); chip_en_n = 1'b1; wait_n(5); end
            1: begin chip_en_n = 1'b0; wait_n(4); oe_rst_n = 1'b0; wait_n(5);
                     oe_rst_n = 1'b1; wait_n(4); end
            2: begin chip_en_n = 1'b0; wait_n(4); cfg_n = 1'b0; wait_n(4);
                     cfg_n = 1'b1; wait_n(5); end
            default: begin jtag_cfg = 1'b1; wait_n(1); jtag_cfg = 1'b0; wait_n(3); end
        endcase
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state with no power-up capture (also R8 negative case)
        use_int = 1'b1; int_rev = 2'd3;
        do_reset(1'b0);
        wait_n(3);
        chk_raw("R1 reset outputs", 0, 0, 0, 1'b0);
        chk_bit("R1 cfg_start idle", cfg_start, 1'b0);
        chk_raw("R8 no capture without pwr_up", 0, 0, 0, 1'b0);

        // R11: reset table contents, entry i at block i, one block
        for (int r = 0; r < 4; r++) begin
            set_sel(1'b1, r); fire(3);
            chk_rev("R11 reset table entry", r);
        end

        // R8: power-up capture on first clock after reset release
        use_int = 1'b1; int_rev = 2'd2;
        do_reset(1'b1);
        wait_n(1);
        chk_raw("R8 power-up capture", 2, 2 << 23, (64'd3 << 23) - 1, 1'b0);
        pwr_up = 1'b0;

        // Program a varied table (R11), with entry 2 empty for R10
        wr_entry(1, 1, 2);
        wr_entry(2, 3, 0);
        wr_entry(3, 4, 3);
        wr_entry(0, 0, 1);

        // R2 R3 R4 R5 R7 R9 R10: sweep source x revision x event
        for (int src = 0; src < 2; src++)
            for (int r = 0; r < 4; r++)
                for (int k = 0; k < 4; k++) begin
                    set_sel(src[0], (r + 1) % 4); fire(3);
                    set_sel(src[0], r);
                    fire(k);
                    case (k)
                        0: chk_rev("R3 R2 R9 R10 ce rise", r);
                        1: chk_rev("R4 R2 R9 R10 oe fall", r);
                        2: chk_rev("R5 R2 R9 R10 cfg rise", r);
                        default: chk_rev("R7 R2 R9 R10 test-port", r);
                    endcase
                end

        // R4 R5: oe fall and cfg rise ignored while chip_en_n high
        set_sel(1'b1, 1); fire(0);
        chk_rev("R3 baseline", 1);
        set_sel(1'b1, 3);
        oe_rst_n = 1'b0; wait_n(5); oe_rst_n = 1'b1; wait_n(5);
        chk_rev("R4 oe fall ignored when disabled", 1);
        cfg_n = 1'b0; wait_n(5); cfg_n = 1'b1; wait_n(5);
        chk_rev("R5 cfg rise ignored when disabled", 1);
        // R3: chip enable falling does not capture
        chip_en_n = 1'b0; wait_n(6);
        chk_rev("R3 ce fall no capture", 1);
        // R4 R5: oe rising and cfg falling do not capture
        oe_rst_n = 1'b0; wait_n(5);
        chk_rev("R4 oe fall captures when enabled", 3);
        set_sel(1'b1, 0);
        oe_rst_n = 1'b1; wait_n(5);
        cfg_n = 1'b0; wait_n(5);
        chk_rev("R5 cfg fall and oe rise no capture", 3);
        cfg_n = 1'b1; wait_n(5);
        chk_rev("R5 cfg rise captures when enabled", 0);

        // R6 R11: table and selection changes without an event do nothing
        set_sel(1'b1, 3); fire(3);
        wr_entry(3, 5, 2);
        set_sel(1'b0, 1); use_int = 1'b1; wait_n(3);
        checks++;
        if (rev_num !== 2'd3 || start_addr !== AW'(4 << 23)) begin
            fails++;
            $display("FAIL R6: got rev=%0d start=%h exp rev=3 start=%h",
                     rev_num, start_addr, AW'(4 << 23));
        end
        int_rev = 2'd3; fire(3);
        chk_rev("R11 new entry after capture", 3);

        // R7: exact timing of capture and start pulse
        int_rev = 2'd1; wait_n(2);
        jtag_cfg = 1'b1; wait_n(1); jtag_cfg = 1'b0;
        chk_rev("R7 capture at first edge", 1);
        chk_bit("R7 no pulse yet", cfg_start, 1'b0);
        wait_n(1);
        chk_bit("R7 pulse high", cfg_start, 1'b1);
        wait_n(1);
        chk_bit("R7 pulse one cycle", cfg_start, 1'b0);

        // R2: synchronised external path with a two-flop delay
        use_int = 1'b0; ext_rev = 2'd0; wait_n(4);
        ext_rev = 2'd3; wait_n(1);
        jtag_cfg = 1'b1; wait_n(1); jtag_cfg = 1'b0;
        chk_rev("R2 external not yet synchronised", 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule